// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block collects 32 interrupt sources and reduces them to two request lines, one critical and one non-critical. Each source has its own configuration: level or edge detection, active-high or active-low sense, and which of the two request lines it drives. Detected events are held in a pending register until software clears them. An enable register gates pending events before they reach the request lines. A masked view of the pending register can be read back, so software can see which sources are asserting a line.

Software reaches the controller through a register port with one write strobe, a 3-bit address, write data and combinational read data. Every register uses the same bit order: source n sits at bit 31−n, so source 0 is the most significant bit. Controllers can be chained. A child's non-critical line is wired into one source input of a parent, and the parent treats it as an active-high level source.

Top module: `cascade_intc`

## Requirements
- R1: Source n (input `irqIn[n]`) maps to register bit 31−n in every register, so source 0 is bit 31.
- R2: Address 0 is the pending register. Writing 1 to a bit clears that bit, and writing 0 to a bit leaves it unchanged. With no write and no new event, the pending bits hold their values.
- R3: Address 1 is the enable register. Address 5 reads pending AND enable and is read-only: a write to it changes no register. A pending source whose enable bit is 0 drives neither request line.
- R4: Address 4 selects the detection mode. A bit of 0 means level detection. A bit of 1 means edge detection: one transition into the active state sets the pending bit once, and the bit stays clear after a clear even while the input remains active.
- R5: Address 3 selects the sense. A bit of 1 means active high (rising edge). A bit of 0 means active low (falling edge).
- R6: Address 2 selects the routing. A bit of 1 sends the source to `critIrq`, and a bit of 0 sends it to `noncritIrq`. Each line is the OR of the enabled pending sources routed to it.
- R7: A level source whose input is still active keeps its pending bit set through a clear. The bit stays clear only once the input is inactive.
- R8: When a new event and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R9: While reset is active, every register reads 0 and both request lines are low. Addresses 6 and 7 read 0.
- R10: Each input passes through a two-flop synchroniser. A change on an input driven between clock edges reaches the pending register on the third rising edge after it, and not before.
- R11: A child's `noncritIrq`, wired into a parent's source input that is set to active-high level, latches in the parent. The parent's pending bit stays set after the child's line drops, until the parent's bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| irqIn | input | 32 | Asynchronous interrupt sources, index = source number |
| critIrq | output | 1 | Critical request line |
| noncritIrq | output | 1 | Non-critical request line, usable as a cascade output |

## Verification
The bench targets the latch-versus-clear races. If an edge arrives in the same cycle as its clear and the clear wins, the event is lost. If a level source does not keep its bit through a clear, the interrupt is dropped while the device is still asserting it. If an edge source re-latches while its input stays active, it interrupts again and again. Other checks catch the bit-order reversal, the polarity sense, the masking done through the read-only masked view, and the synchroniser latency. A latency check fails if a stage is added or removed. A last test chains two controllers and shows that the parent's pending bit outlives the child's request.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CRIT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_POL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TRIG = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MSK  = 3'd5;

  // Strobes from the control decode into the datapath
  typedef struct packed {
    logic              wrStat;
    logic              wrEn;
    logic              wrCrit;
    logic              wrPol;
    logic              wrTrig;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStrobeT;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strb
);
  always_comb begin
    strb        = '0;
    strb.rdSel  = regAddr;
    if (regWrEn) begin
      case (regAddr)
        ADDR_STAT: strb.wrStat = 1'b1;
        ADDR_EN:   strb.wrEn   = 1'b1;
        ADDR_CRIT: strb.wrCrit = 1'b1;
        ADDR_POL:  strb.wrPol  = 1'b1;
        ADDR_TRIG: strb.wrTrig = 1'b1;
        default:   ;
      endcase
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStat, strb.wrEn, strb.wrCrit, strb.wrPol, strb.wrTrig})); // R9

  AST_MSK_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_MSK) |-> !(strb.wrStat || strb.wrEn || strb.wrCrit || strb.wrPol || strb.wrTrig)); // R3
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               critIrq,
  output logic               noncritIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] srcBits;
  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] statQ, enQ, critQ, polQ, trigQ, prevQ;
  logic [NUM_SRC-1:0] active, edgeEvt, setEvt, clrMask, masked;

  // Source n lands on register bit NUM_SRC-1-n
  for (genvar n = 0; n < NUM_SRC; n++) begin : gRev
    assign srcBits[NUM_SRC-1-n] = srcIn[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= srcBits;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  assign active  = ~(syncQ[LAST] ^ polQ);
  assign edgeEvt = active & ~prevQ;
  assign setEvt  = (trigQ & edgeEvt) | (~trigQ & active);
  assign clrMask = strb.wrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enQ   <= '0;
      critQ <= '0;
      polQ  <= '0;
      trigQ <= '0;
      prevQ <= '0;
    end else begin
      prevQ <= active;
      statQ <= (statQ & ~clrMask) | setEvt;
      if (strb.wrEn)   enQ   <= wrData;
      if (strb.wrCrit) critQ <= wrData;
      if (strb.wrPol)  polQ  <= wrData;
      if (strb.wrTrig) trigQ <= wrData;
    end
  end

  assign masked     = statQ & enQ;
  assign critIrq    = |(masked & critQ);
  assign noncritIrq = |(masked & ~critQ);

  always_comb begin
    case (strb.rdSel)
      ADDR_STAT: rdData = statQ;
      ADDR_EN:   rdData = enQ;
      ADDR_CRIT: rdData = critQ;
      ADDR_POL:  rdData = polQ;
      ADDR_TRIG: rdData = trigQ;
      ADDR_MSK:  rdData = masked;
      default:   rdData = '0;
    endcase
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && setEvt == '0) |=> ((statQ & $past(wrData)) == '0)); // R2

  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrStat && setEvt == '0) |=> $stable(statQ)); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setEvt != '0) |=> ((statQ & $past(setEvt)) == $past(setEvt))); // R8

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> (!critIrq && !noncritIrq)); // R3

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && ((wrData & trigQ & active & prevQ) != '0))
      |=> ((statQ & $past(wrData & trigQ & active & prevQ)) == '0)); // R4
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               critIrq,
  output logic               noncritIrq
);
  ctrlStrobeT strb;

  intc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(2)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .srcIn      (irqIn),
    .rdData     (regRdData),
    .critIrq    (critIrq),
    .noncritIrq (noncritIrq)
  );
endmodule

// File: tb/sim_cascade_intc.sv
module sim_cascade_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq = 32'hFFFF_FFFF;
  logic        crit, non;

  logic        pWe = 1'b0;
  logic [2:0]  pAddr = 3'd0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic [31:0] pIrq;
  logic        pCrit, pNon;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cascade_intc u0 (.clk(clk), .rstN(rstN), .regWrEn(we), .regAddr(addr),
    .regWrData(wdata), .regRdData(rdata), .irqIn(irq), .critIrq(crit), .noncritIrq(non));

  // Child non-critical line drives parent source 3 (parent register bit 28)
  assign pIrq = {28'hFFF_FFFF, non, 3'b111};

  cascade_intc uParent (.clk(clk), .rstN(rstN), .regWrEn(pWe), .regAddr(pAddr),
    .regWrData(pWdata), .regRdData(pRdata), .irqIn(pIrq), .critIrq(pCrit), .noncritIrq(pNon));

  typedef struct packed {
    logic [31:0] irqV;
    logic        wr;
    logic [2:0]  a;
    logic [31:0] d;
    logic [3:0]  waitN;
    logic [31:0] expRd;
    logic        expCrit;
    logic        expNon;
    logic [7:0]  req;
  } vecT;

  localparam vecT VECS [15] = '{
    '{32'hFFFF_FFFF, 1'b1, 3'd1, 32'hFFFF_FFFF, 4'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd3}, // R3 enable all
    '{32'hFFFF_FFFF, 1'b1, 3'd3, 32'h8000_0000, 4'd2, 32'h8000_0000, 1'b0, 1'b1, 8'd5}, // R5 src0 active high
    '{32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0,         4'd0, 32'h8000_0000, 1'b0, 1'b1, 8'd1}, // R1 src0 at MSB
    '{32'hFFFF_FFFF, 1'b1, 3'd0, 32'h8000_0000, 4'd1, 32'h8000_0000, 1'b0, 1'b1, 8'd7}, // R7 level resets
    '{32'hFFFF_FFFF, 1'b1, 3'd2, 32'h8000_0000, 4'd1, 32'h8000_0000, 1'b1, 1'b0, 8'd6}, // R6 route critical
    '{32'hFFFF_FFFE, 1'b0, 3'd0, 32'h0,         4'd3, 32'h8000_0000, 1'b1, 1'b0, 8'd2}, // R2 held after inactive
    '{32'hFFFF_FFFE, 1'b1, 3'd0, 32'h8000_0000, 4'd1, 32'h0,         1'b0, 1'b0, 8'd2}, // R2 clear
    '{32'hFFFF_FFFE, 1'b1, 3'd4, 32'h0400_0000, 4'd1, 32'h0400_0000, 1'b0, 1'b0, 8'd4}, // R4 src5 edge
    '{32'hFFFF_FFDE, 1'b0, 3'd0, 32'h0,         4'd4, 32'h0400_0000, 1'b0, 1'b1, 8'd5}, // R5 falling edge
    '{32'hFFFF_FFDE, 1'b1, 3'd0, 32'h0400_0000, 4'd2, 32'h0,         1'b0, 1'b0, 8'd4}, // R4 no re-latch
    '{32'hFFFF_FFFF, 1'b1, 3'd1, 32'h7FFF_FFFF, 4'd4, 32'h7FFF_FFFF, 1'b0, 1'b0, 8'd3}, // R3 mask src0
    '{32'hFFFF_FFFF, 1'b0, 3'd5, 32'h0,         4'd0, 32'h0,         1'b0, 1'b0, 8'd3}, // R3 masked view
    '{32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0,         4'd0, 32'h8000_0000, 1'b0, 1'b0, 8'd3}, // R3 pending but masked
    '{32'hFFFF_FFFF, 1'b1, 3'd5, 32'hFFFF_FFFF, 4'd0, 32'h0,         1'b0, 1'b0, 8'd3}, // R3 read-only
    '{32'hFFFF_FFFF, 1'b0, 3'd6, 32'h0,         4'd0, 32'h0,         1'b0, 1'b0, 8'd9}  // R9 unused addr
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); pWe = 1'b1; pAddr = a; pWdata = d;
    @(negedge clk); pWe = 1'b0; pAddr = 3'd0;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    // R9 reset state
    waitN(3);
    for (int a = 0; a < 8; a++) begin
      addr = a[2:0];
      #0.1;
      check("R9 reset read", rdata, 32'h0);
    end
    check("R9 reset lines", {30'h0, crit, non}, 32'h0);
    addr = 3'd0;
    @(negedge clk); rstN = 1'b1;
    waitN(4);
    cWr(3'd0, 32'hFFFF_FFFF);
    pWr(3'd3, 32'h1000_0000);
    pWr(3'd1, 32'h1000_0000);
    pWr(3'd0, 32'hFFFF_FFFF);
    waitN(2);

    foreach (VECS[i]) begin
      @(negedge clk);
      irq = VECS[i].irqV; we = VECS[i].wr; addr = VECS[i].a; wdata = VECS[i].d;
      @(negedge clk); we = 1'b0;
      waitN(VECS[i].waitN);
      check($sformatf("R%0d vec%0d read", VECS[i].req, i), rdata, VECS[i].expRd);
      check($sformatf("R%0d vec%0d lines", VECS[i].req, i), {30'h0, crit, non},
            {30'h0, VECS[i].expCrit, VECS[i].expNon});
    end

    // R10 latency: pending on third rising edge, not earlier
    addr = 3'd0;
    @(negedge clk); irq = 32'hFFFF_FFDF;
    @(negedge clk); check("R10 after 1 edge", rdata & 32'h0400_0000, 32'h0);
    @(negedge clk); check("R10 after 2 edges", rdata & 32'h0400_0000, 32'h0);
    @(negedge clk); check("R10 after 3 edges", rdata & 32'h0400_0000, 32'h0400_0000);

    // R8 edge and clear in the same cycle
    irq = 32'hFFFF_FFFF;
    waitN(4);
    @(negedge clk); irq = 32'hFFFF_FFDF;
    @(negedge clk);
    @(negedge clk); we = 1'b1; wdata = 32'h0400_0000;
    @(negedge clk); we = 1'b0;
    check("R8 event beats clear", rdata & 32'h0400_0000, 32'h0400_0000);
    cWr(3'd0, 32'h0400_0000);
    check("R2 clear without event", rdata & 32'h0400_0000, 32'h0);

    // R11 cascade into parent
    irq = 32'hFFFF_FFFF;
    waitN(4);
    irq = 32'hFFFF_FFDF;
    waitN(8);
    check("R11 child line", {31'h0, non}, 32'h1);
    check("R11 parent pending", pRdata, 32'h1000_0000);
    check("R11 parent line", {31'h0, pNon}, 32'h1);
    cWr(3'd0, 32'h0400_0000);
    waitN(4);
    check("R11 child dropped", {31'h0, non}, 32'h0);
    check("R11 parent latched", pRdata, 32'h1000_0000);
    pWr(3'd0, 32'h1000_0000);
    check("R11 parent cleared", {31'h0, pNon}, 32'h0);
    finish();
  end
endmodule